// File: doc/BRIEF.md
# FPGA Configuration-Memory Streamer

This block is a master that loads an FPGA's volatile configuration memory over a serial link. On a load request it holds the target in reset with its select line low, and then releases reset while keeping select low. After a settling time it streams configuration bytes from a valid/ready byte input onto a serial data line, with a serial clock that idles low. When the byte marked last has gone out, it issues a fixed run of trailing clocks and then samples the target's configuration-done input. It reports the result as success or error.

A second request lets the target boot from its own non-volatile memory. The block pulses reset with select held high, releases both lines and waits a longer settling time. It then samples done in the same way. Every wait is a cycle-count parameter that the integrator derives from the system clock frequency.

Top module: `cfg_streamer`

## Requirements
- R1: While and after rst_ni is low, spi_cs_no and cfg_reset_no are 1, and spi_sck_o, byte_ready_o, fin_o, ok_o and err_o are 0.
- R2: A load request (sram_go_i) taken in idle drives spi_cs_no and cfg_reset_no low on the same clock edge. cfg_reset_no then stays low for exactly T_RST_CYC cycles.
- R3: cfg_reset_no then rises while spi_cs_no stays low. For exactly T_WAKE_CYC cycles no serial clock runs and byte_ready_o stays 0. After that, byte_ready_o rises.
- R4: Each byte goes out most significant bit first. spi_sck_o idles low and each half period lasts HALF_CYC clock cycles. spi_mosi_o changes only while spi_sck_o is low, right after a falling edge or at a load, so the target samples on the rising edge.
- R5: When the next byte is already valid at the last falling edge of the current byte, it is loaded at that edge. Rising clock edges then stay evenly spaced by 2*HALF_CYC cycles across byte boundaries.
- R6: A byte is taken on a cycle where byte_valid_i and byte_ready_o are both 1. byte_ready_o is 1 only during streaming. If no byte is offered, the serial clock stays low and no byte is lost or repeated.
- R7: After the byte flagged by byte_last_i, exactly 6*8+1 = 49 further rising clocks follow back to back, with spi_mosi_o at 0 and spi_cs_no still low.
- R8: After the trailing clocks the synchronized cfg_done_i is sampled. fin_o goes to 1, and ok_o is 1 if done was high while err_o is 1 if it was low. ok_o and err_o are never both 1. The three hold until the next accepted request.
- R9: A boot request (flash_go_i) keeps spi_cs_no high throughout and produces no serial clock. It drives cfg_reset_no low for T_RST_CYC cycles and then leaves both lines high for T_FLASH_CYC cycles. It then reports done as in R8.
- R10: Requests that arrive while a sequence is running are ignored. cfg_reset_no does not fall again and the result of the running sequence stands.
- R11: If sram_go_i and flash_go_i arrive in the same cycle, the load sequence is taken.
- R12: An accepted request clears fin_o, ok_o and err_o on the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sram_go_i | input | 1 | Request a direct configuration load |
| flash_go_i | input | 1 | Request a boot from the target's own memory |
| byte_data_i | input | 8 | Configuration byte |
| byte_valid_i | input | 1 | Byte offered |
| byte_last_i | input | 1 | Offered byte is the final one |
| byte_ready_o | output | 1 | Byte taken this cycle when valid |
| spi_sck_o | output | 1 | Serial clock, idles low |
| spi_mosi_o | output | 1 | Serial data to target |
| spi_cs_no | output | 1 | Target select, active low |
| cfg_reset_no | output | 1 | Target reset, active low |
| cfg_done_i | input | 1 | Target configuration-done level (asynchronous) |
| fin_o | output | 1 | A sequence has completed |
| ok_o | output | 1 | Done was high at the sample |
| err_o | output | 1 | Done was low at the sample |

## Verification
The load path is driven with bursts of one, three, four and five bytes, using varied byte values including all zeros and all ones. A burst offered back to back shows that bytes are handed over at the final falling edge with no lost clock. Bursts with idle gaps of one and three cycles show that the clock pauses instead of dropping or repeating a byte. Runs with done held high and held low, in both load and boot modes, separate the success and error reports. Directed cases measure the reset and settling windows, requests made during a busy sequence, and two requests arriving in the same cycle.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST,
    ST_WAKE,
    ST_STREAM,
    ST_DRAIN,
    ST_DUMMY,
    ST_FL_RST,
    ST_FL_WAIT,
    ST_SAMPLE
  } cfg_st_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [TW-1:0] lim_i,
  output logic          hit_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + TW'(1);
  end

  assign hit_o = run_i && (cnt_q == lim_i - TW'(1));
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int HALF_CYC = 4,
  parameter int BITS_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [7:0]        ld_data_i,
  input  logic [BITS_W-1:0] ld_bits_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [7:0]        sreg_q;
  logic [BITS_W-1:0] bits_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sck_q, mosi_q, busy_q;
  logic              half_end, last_fall;

  assign half_end  = (cnt_q == CNT_W'(HALF_CYC - 1));
  assign last_fall = busy_q && sck_q && half_end && (bits_q == BITS_W'(1));
  assign accept_o  = !busy_q || last_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      bits_q <= '0;
      cnt_q  <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (ld_i && accept_o) begin
      // next bit always waits in sreg_q[7]
      sreg_q <= {ld_data_i[6:0], 1'b0};
      mosi_q <= ld_data_i[7];
      bits_q <= ld_bits_i;
      cnt_q  <= '0;
      sck_q  <= 1'b0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (half_end) begin
        cnt_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
        end else begin
          sck_q  <= 1'b0;
          bits_q <= bits_q - BITS_W'(1);
          if (bits_q == BITS_W'(1)) begin
            busy_q <= 1'b0;
          end else begin
            mosi_q <= sreg_q[7];
            sreg_q <= {sreg_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer
  import cfg_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int T_RST_CYC   = 5000,
  parameter int T_WAKE_CYC  = 100000,
  parameter int T_FLASH_CYC = 12500000,
  parameter int DUMMY_BYTES = 6,
  parameter int DUMMY_BITS  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sram_go_i,
  input  logic       flash_go_i,
  input  logic [7:0] byte_data_i,
  input  logic       byte_valid_i,
  input  logic       byte_last_i,
  output logic       byte_ready_o,
  output logic       spi_sck_o,
  output logic       spi_mosi_o,
  output logic       spi_cs_no,
  output logic       cfg_reset_no,
  input  logic       cfg_done_i,
  output logic       fin_o,
  output logic       ok_o,
  output logic       err_o
);
  localparam int DUMMY_CLKS = DUMMY_BYTES * 8 + DUMMY_BITS;
  localparam int BITS_MAX   = (DUMMY_CLKS > 8) ? DUMMY_CLKS : 8;
  localparam int BITS_W     = $clog2(BITS_MAX + 1);
  localparam int T_MAX01    = (T_RST_CYC > T_WAKE_CYC) ? T_RST_CYC : T_WAKE_CYC;
  localparam int T_MAX      = (T_MAX01 > T_FLASH_CYC) ? T_MAX01 : T_FLASH_CYC;
  localparam int TW         = $clog2(T_MAX + 1);

  cfg_st_e st_q, st_d;
  logic    t_hit, t_run, t_clr;
  logic [TW-1:0] t_lim;
  logic    sh_ld, sh_accept, sh_busy;
  logic [7:0]        sh_data;
  logic [BITS_W-1:0] sh_bits;
  logic    done_s;
  logic    cs_q, crst_q, fin_q, ok_q, err_q;
  logic    take_byte;

  cfg_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cfg_done_i),
    .q_o   (done_s)
  );

  always_comb begin
    t_run = 1'b0;
    t_lim = TW'(T_RST_CYC);
    unique case (st_q)
      ST_RST, ST_FL_RST: begin t_run = 1'b1; t_lim = TW'(T_RST_CYC);   end
      ST_WAKE:           begin t_run = 1'b1; t_lim = TW'(T_WAKE_CYC);  end
      ST_FL_WAIT:        begin t_run = 1'b1; t_lim = TW'(T_FLASH_CYC); end
      default: ;
    endcase
  end

  assign t_clr = (st_d != st_q);

  cfg_timer #(.TW(TW)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (t_clr),
    .run_i (t_run),
    .lim_i (t_lim),
    .hit_o (t_hit)
  );

  assign take_byte = (st_q == ST_STREAM) && byte_valid_i && sh_accept;
  assign sh_ld     = take_byte || ((st_q == ST_DRAIN) && sh_accept);
  assign sh_data   = (st_q == ST_STREAM) ? byte_data_i : 8'h00;
  assign sh_bits   = (st_q == ST_STREAM) ? BITS_W'(8) : BITS_W'(DUMMY_CLKS);

  cfg_shifter #(.HALF_CYC(HALF_CYC), .BITS_W(BITS_W)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (sh_ld),
    .ld_data_i(sh_data),
    .ld_bits_i(sh_bits),
    .accept_o (sh_accept),
    .busy_o   (sh_busy),
    .sck_o    (spi_sck_o),
    .mosi_o   (spi_mosi_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (sram_go_i)       st_d = ST_RST;
        else if (flash_go_i) st_d = ST_FL_RST;
      end
      ST_RST:     if (t_hit) st_d = ST_WAKE;
      ST_WAKE:    if (t_hit) st_d = ST_STREAM;
      ST_STREAM:  if (take_byte && byte_last_i) st_d = ST_DRAIN;
      ST_DRAIN:   if (sh_accept) st_d = ST_DUMMY;
      ST_DUMMY:   if (!sh_busy) st_d = ST_SAMPLE;
      ST_FL_RST:  if (t_hit) st_d = ST_FL_WAIT;
      ST_FL_WAIT: if (t_hit) st_d = ST_SAMPLE;
      ST_SAMPLE:  st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cs_q   <= 1'b1;
      crst_q <= 1'b1;
      fin_q  <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      // pins registered from next state: no decode glitches
      crst_q <= !((st_d == ST_RST) || (st_d == ST_FL_RST));
      unique case (st_d)
        ST_RST, ST_WAKE, ST_STREAM, ST_DRAIN, ST_DUMMY: cs_q <= 1'b0;
        ST_SAMPLE: cs_q <= cs_q;
        default:   cs_q <= 1'b1;
      endcase
      if (st_q == ST_IDLE && st_d != ST_IDLE) begin
        fin_q <= 1'b0;
        ok_q  <= 1'b0;
        err_q <= 1'b0;
      end else if (st_q == ST_SAMPLE) begin
        fin_q <= 1'b1;
        ok_q  <= done_s;
        err_q <= !done_s;
      end
    end
  end

  assign byte_ready_o = (st_q == ST_STREAM) && sh_accept;
  assign spi_cs_no    = cs_q;
  assign cfg_reset_no = crst_q;
  assign fin_o        = fin_q;
  assign ok_o         = ok_q;
  assign err_o        = err_q;
endmodule

// File: rtl/cfg_streamer_chk.sv
module cfg_streamer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sram_go_i,
  input logic flash_go_i,
  input logic byte_ready_o,
  input logic spi_sck_o,
  input logic spi_mosi_o,
  input logic spi_cs_no,
  input logic cfg_reset_no,
  input logic fin_o,
  input logic ok_o,
  input logic err_o
);
  AST_CS_RST_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cfg_reset_no) && !spi_cs_no) |-> $fell(spi_cs_no)); // R2

  AST_SCK_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sck_o |-> (!spi_cs_no && cfg_reset_no)); // R3

  AST_MOSI_HOLD_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sck_o |-> $stable(spi_mosi_o)); // R4

  AST_RDY_STREAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> (!spi_cs_no && cfg_reset_no && !fin_o)); // R6

  AST_RESULT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> ($countones({ok_o, err_o}) == 1)); // R8

  AST_NO_VERDICT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_o |-> (!ok_o && !err_o)); // R8

  AST_FIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_o && !sram_go_i && !flash_go_i) |=> fin_o); // R8

  AST_FLASH_NO_SCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o); // R9
endmodule

bind cfg_streamer cfg_streamer_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sram_go_i   (sram_go_i),
  .flash_go_i  (flash_go_i),
  .byte_ready_o(byte_ready_o),
  .spi_sck_o   (spi_sck_o),
  .spi_mosi_o  (spi_mosi_o),
  .spi_cs_no   (spi_cs_no),
  .cfg_reset_no(cfg_reset_no),
  .fin_o       (fin_o),
  .ok_o        (ok_o),
  .err_o       (err_o)
);

// File: tb/test_cfg_streamer.sv
`timescale 1ns/1ps
module test_cfg_streamer;
  localparam int HALF  = 2;
  localparam int TRST  = 10;
  localparam int TWAKE = 20;
  localparam int TFL   = 30;
  localparam int NDUM  = 49;

  typedef struct packed {
    logic       flash;
    logic [5:0] n;
    logic [7:0] seed;
    logic [2:0] gap;
    logic       done;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 6'd4, 8'hA5, 3'd0, 1'b1},
    '{1'b0, 6'd1, 8'h3C, 3'd0, 1'b1},
    '{1'b0, 6'd3, 8'h00, 3'd3, 1'b1},
    '{1'b0, 6'd5, 8'hFF, 3'd1, 1'b0},
    '{1'b1, 6'd0, 8'h00, 3'd0, 1'b1},
    '{1'b1, 6'd0, 8'h00, 3'd0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sram_go = 1'b0, flash_go = 1'b0;
  logic [7:0] bdata = '0;
  logic bvalid = 1'b0, blast = 1'b0, done_in = 1'b0;
  logic bready, sck, mosi, cs_n, crst_n, fin, ok, err;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  cfg_streamer #(
    .HALF_CYC(HALF), .T_RST_CYC(TRST), .T_WAKE_CYC(TWAKE), .T_FLASH_CYC(TFL)
  ) i_cfg_streamer (
    .clk_i(clk), .rst_ni(rst_n), .sram_go_i(sram_go), .flash_go_i(flash_go),
    .byte_data_i(bdata), .byte_valid_i(bvalid), .byte_last_i(blast),
    .byte_ready_o(bready), .spi_sck_o(sck), .spi_mosi_o(mosi),
    .spi_cs_no(cs_n), .cfg_reset_no(crst_n), .cfg_done_i(done_in),
    .fin_o(fin), .ok_o(ok), .err_o(err)
  );

  // target model: samples on rising serial clock
  int exp_n = 0, nbits = 0, dum_ones = 0, cs_low = 0, rst_falls = 0;
  logic [7:0] shreg = '0;
  logic [7:0] cap [64];
  realtime t_first = 0, t_data_end = 0, t_last = 0;
  logic prev_crst = 1'b1;

  always @(posedge sck) begin
    if (!cs_n) begin
      nbits = nbits + 1;
      shreg = {shreg[6:0], mosi};
      if (nbits == 1) t_first = $realtime;
      if (nbits == 8 * exp_n) t_data_end = $realtime;
      t_last = $realtime;
      if (nbits <= 8 * exp_n) begin
        if (nbits % 8 == 0) cap[(nbits - 1) / 8] = shreg;
      end else if (mosi) begin
        dum_ones = dum_ones + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!cs_n) cs_low = cs_low + 1;
    if (prev_crst && !crst_n) rst_falls = rst_falls + 1;
    prev_crst = crst_n;
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon(input int n);
    exp_n = n; nbits = 0; dum_ones = 0; cs_low = 0; rst_falls = 0;
  endtask

  function automatic logic [7:0] bval(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  task automatic send_bytes(input int n, input logic [7:0] seed, input int gap);
    for (int i = 0; i < n; i++) begin
      bdata = bval(seed, i); bvalid = 1'b1; blast = (i == n - 1);
      for (int k = 0; k < 4000 && !bready; k++) @(negedge clk);
      @(negedge clk);
      if (gap > 0) begin
        bvalid = 1'b0; blast = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    bvalid = 1'b0; blast = 1'b0;
  endtask

  task automatic wait_fin();
    for (int k = 0; k < 5000 && !fin; k++) @(negedge clk);
  endtask

  task automatic pulse(input bit s, input bit f);
    @(negedge clk); sram_go = s; flash_go = f;
    @(negedge clk); sram_go = 1'b0; flash_go = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cs_n && crst_n && !sck && !bready && !fin && !ok && !err, "R1",
        {cs_n, crst_n, sck, bready, fin, ok, err}, 7'b1100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && crst_n && !sck && !fin, "R1 after release", {cs_n, crst_n, sck, fin}, 4'b1100);

    // vector table
    for (int v = 0; v < 6; v++) begin
      clr_mon(VECS[v].flash ? 0 : int'(VECS[v].n));
      done_in = VECS[v].done;
      pulse(!VECS[v].flash, VECS[v].flash);
      chk(!fin && !ok && !err, "R12 cleared on start", {fin, ok, err}, 0);
      if (!VECS[v].flash) send_bytes(VECS[v].n, VECS[v].seed, VECS[v].gap);
      wait_fin();
      chk(fin && ok == VECS[v].done && err == !VECS[v].done, "R8 verdict",
          {fin, ok, err}, {1'b1, VECS[v].done, !VECS[v].done});
      if (VECS[v].flash) begin
        chk(cs_low == 0, "R9 select stays high", cs_low, 0);
        chk(nbits == 0, "R9 no serial clock", nbits, 0);
      end else begin
        chk(nbits == 8 * exp_n + NDUM, "R7 clock count", nbits, 8 * exp_n + NDUM);
        chk(dum_ones == 0, "R7 trailing data low", dum_ones, 0);
        for (int i = 0; i < exp_n; i++)
          chk(cap[i] == bval(VECS[v].seed, i), "R4 R6 byte value", cap[i], bval(VECS[v].seed, i));
        if (VECS[v].gap == 0) begin
          chk(int'((t_data_end - t_first) / 20.0) == (8 * exp_n - 1) * 2 * HALF, "R5 gapless bytes",
              int'((t_data_end - t_first) / 20.0), (8 * exp_n - 1) * 2 * HALF);
          chk(int'((t_last - t_data_end) / 20.0) == NDUM * 2 * HALF, "R7 trailing clocks contiguous",
              int'((t_last - t_data_end) / 20.0), NDUM * 2 * HALF);
        end
      end
      repeat (5) @(negedge clk);
    end

    // R2 R3: reset and settling windows
    begin
      int lo, wk;
      clr_mon(1); done_in = 1'b1; lo = 0; wk = 0;
      @(negedge clk); sram_go = 1'b1;
      @(negedge clk); sram_go = 1'b0;
      chk(!cs_n && !crst_n, "R2 select and reset low together", {cs_n, crst_n}, 0);
      while (!crst_n && lo < 1000) begin lo++; @(negedge clk); end
      chk(lo == TRST, "R2 reset width", lo, TRST);
      while (crst_n && !cs_n && !bready && !sck && wk < 1000) begin wk++; @(negedge clk); end
      chk(wk == TWAKE && bready, "R3 settling window", wk, TWAKE);
      send_bytes(1, 8'h81, 0);
      wait_fin();
      chk(ok && cap[0] == 8'h81, "R4 single byte", cap[0], 8'h81);
    end

    // R10: requests while busy are ignored
    repeat (3) @(negedge clk);
    clr_mon(2); done_in = 1'b0;
    pulse(1'b1, 1'b0);
    repeat (TRST + 3) @(negedge clk);
    sram_go = 1'b1; flash_go = 1'b1;
    @(negedge clk); sram_go = 1'b0; flash_go = 1'b0;
    send_bytes(2, 8'h5A, 0);
    wait_fin();
    repeat (20) @(negedge clk);
    chk(rst_falls == 1, "R10 no restart", rst_falls, 1);
    chk(fin && err && !ok, "R10 result stands", {fin, ok, err}, 3'b101);

    // R11: simultaneous requests take the load path
    clr_mon(1); done_in = 1'b1;
    pulse(1'b1, 1'b1);
    chk(!cs_n && !crst_n, "R11 load path wins", {cs_n, crst_n}, 0);
    send_bytes(1, 8'h42, 0);
    wait_fin();
    chk(fin && ok && nbits == 8 + NDUM, "R11 load completes", nbits, 8 + NDUM);

    // R6: late byte keeps clock parked low
    clr_mon(1); done_in = 1'b1;
    pulse(1'b1, 1'b0);
    repeat (TRST + TWAKE + 10) @(negedge clk);
    chk(nbits == 0 && !sck && bready, "R6 no clock without byte", nbits, 0);
    send_bytes(1, 8'hC3, 0);
    wait_fin();
    chk(cap[0] == 8'hC3, "R6 late byte intact", cap[0], 8'hC3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule